// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Controller

This block keeps one small register bank for each core of a multi-core cluster. Each bank holds a 32-bit pending word, a 32-bit enable word and eight 32-bit mailbox words. Every bank drives one level interrupt line toward its core. The pending word cannot be written directly. Bits enter it through a write-one-to-set port and leave it through a write-one-to-clear port. The rules that raise and lower the interrupt differ on purpose: a set raises the line whenever any pending bit is also enabled; a clear drops it only when the pending word becomes empty and the enable word is not empty.

Cores reach the block through a single 32-bit access port. Each access carries the requester's core number, which selects the bank that a local register access touches. Only the low eight address bits are decoded. A send register lets any requester post a one-hot bit into another core's pending word. The write data names the target core and a 5-bit vector, and the vector is turned into a one-hot set mask. A send that names a core which does not exist is refused with an error flag. Every access gets a registered response one cycle later.

Top module: `ipi_ctrl`

## Requirements
- R1: After reset every pending word, enable word and mailbox word reads as zero, and every interrupt output is low.
- R2: Offset 0x00 reads the requester's pending word. A write to 0x00 changes nothing and returns the error flag set.
- R3: A write to offset 0x08 ORs the write data into the requester's pending word. The interrupt goes high if the new pending word ANDed with enable is nonzero; otherwise it keeps its value.
- R4: A write to offset 0x0C clears in the pending word each bit that is 1 in the write data. The interrupt goes low only if the new pending word is zero and enable is nonzero; otherwise it keeps its value.
- R5: Offsets 0x08 and 0x0C always read as zero. A write to offset 0x04 replaces the enable word and leaves both the pending word and the interrupt unchanged.
- R6: The eight aligned offsets 0x20, 0x24, … 0x3C hold mailbox words 0 to 7, where the word index is (offset − 0x20) / 4. Each word reads back what was last written to it.
- R7: A write to offset 0x40 takes the target core from bits 25:16 and the vector from bits 4:0. It then acts as a 0x08 write of (1 << vector) on the target core's bank, whatever the requester's number.
- R8: A 0x40 write whose target core is at or above NCORES returns the error flag set and changes no pending word, enable word or interrupt.
- R9: Address bits above bit 7 are ignored. Reads of any other offset (including unaligned mailbox addresses), and reads with a requester number at or above NCORES, return zero. Writes to those offsets, and local writes from such requesters, have no effect and no error.
- R10: Each access cycle with req_valid high is answered in the next cycle by rsp_valid high, together with rsp_rdata and rsp_err. Write accesses return zero data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address, low 8 bits decoded |
| req_id | input | ID_W | Requester core number, selects the bank |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access refused (pending write or bad send target) |
| irq_o | output | NCORES | Level interrupt, one per core |

## Verification
The bench builds the controller with NCORES = 3, ID_W = 10 and ADDR_W = 12. A core count that is not a power of two puts every send target from 3 to 1023 out of range. Requester number 3 and above also lands on no bank, and random upper address bits test that only the low byte is decoded. Three banks are few enough that random sets, clears and sends often hit the same core. That drives the pending words back to zero and reaches the cases where the interrupt is kept high while enable is zero.

// File: rtl/ipi_ctrl_pkg.sv
package ipi_ctrl_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned MBOX_WORDS = 8;
  localparam int unsigned MBOX_IDX_W = $clog2(MBOX_WORDS);

  localparam logic [7:0] OFF_PEND    = 8'h00;
  localparam logic [7:0] OFF_ENABLE  = 8'h04;
  localparam logic [7:0] OFF_SET     = 8'h08;
  localparam logic [7:0] OFF_CLEAR   = 8'h0C;
  localparam logic [7:0] OFF_MBOX_LO = 8'h20;
  localparam logic [7:0] OFF_MBOX_HI = 8'h3C;
  localparam logic [7:0] OFF_SEND    = 8'h40;

  localparam int unsigned TGT_LSB = 16;
  localparam int unsigned TGT_W   = 10;
  localparam int unsigned VEC_W   = 5;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_PEND,
    ACC_ENABLE,
    ACC_SET,
    ACC_CLEAR,
    ACC_MBOX,
    ACC_SEND
  } acc_kind_e;

  function automatic acc_kind_e classify(input logic [7:0] off);
    if (off == OFF_PEND)        return ACC_PEND;
    else if (off == OFF_ENABLE) return ACC_ENABLE;
    else if (off == OFF_SET)    return ACC_SET;
    else if (off == OFF_CLEAR)  return ACC_CLEAR;
    else if (off == OFF_SEND)   return ACC_SEND;
    else if (off >= OFF_MBOX_LO && off <= OFF_MBOX_HI && off[1:0] == 2'b00)
      return ACC_MBOX;
    else                        return ACC_NONE;
  endfunction

  function automatic logic [MBOX_IDX_W-1:0] mbox_index(input logic [7:0] off);
    logic [7:0] rel;
    rel = off - OFF_MBOX_LO;
    return rel[MBOX_IDX_W+1:2];
  endfunction

  function automatic logic [WORD_W-1:0] vec_to_mask(input logic [VEC_W-1:0] vec);
    return WORD_W'(1) << vec;
  endfunction

  function automatic logic [WORD_W-1:0] pend_after_set(input logic [WORD_W-1:0] pend,
                                                       input logic [WORD_W-1:0] bits);
    return pend | bits;
  endfunction

  function automatic logic [WORD_W-1:0] pend_after_clear(input logic [WORD_W-1:0] pend,
                                                         input logic [WORD_W-1:0] bits);
    return pend & ~bits;
  endfunction

  function automatic logic irq_after_set(input logic cur,
                                         input logic [WORD_W-1:0] new_pend,
                                         input logic [WORD_W-1:0] en);
    return ((new_pend & en) != '0) ? 1'b1 : cur;
  endfunction

  function automatic logic irq_after_clear(input logic cur,
                                           input logic [WORD_W-1:0] new_pend,
                                           input logic [WORD_W-1:0] en);
    return (new_pend == '0 && en != '0) ? 1'b0 : cur;
  endfunction

endpackage

// File: rtl/ipi_access_decode.sv
module ipi_access_decode
  import ipi_ctrl_pkg::*;
#(
  parameter int unsigned NCORES = 4,
  parameter int unsigned ID_W   = 10
) (
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [7:0]            req_off,
  input  logic [ID_W-1:0]       req_id,
  input  logic [TGT_W-1:0]      send_tgt,
  input  logic [VEC_W-1:0]      send_vec,
  output acc_kind_e             kind,
  output logic [MBOX_IDX_W-1:0] mbox_idx,
  output logic [NCORES-1:0]     local_hit,
  output logic [NCORES-1:0]     send_hit,
  output logic [WORD_W-1:0]     send_mask,
  output logic                  acc_err
);

  logic is_send_wr;
  logic tgt_in_range;

  assign kind         = classify(req_off);
  assign mbox_idx     = mbox_index(req_off);
  assign send_mask    = vec_to_mask(send_vec);
  assign is_send_wr   = req_valid && req_write && (kind == ACC_SEND);
  assign tgt_in_range = (32'(send_tgt) < NCORES);

  for (genvar i = 0; i < NCORES; i++) begin : g_hit
    assign local_hit[i] = req_valid && (32'(req_id) == i);
    assign send_hit[i]  = is_send_wr && tgt_in_range && (32'(send_tgt) == i);
  end

  assign acc_err = (req_valid && req_write && kind == ACC_PEND) ||
                   (is_send_wr && !tgt_in_range);

endmodule

// File: rtl/ipi_core_bank.sv
module ipi_core_bank
  import ipi_ctrl_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en_we,
  input  logic                         set_we,
  input  logic [WORD_W-1:0]            set_bits,
  input  logic                         clr_we,
  input  logic                         mbox_we,
  input  logic [MBOX_IDX_W-1:0]        mbox_idx,
  input  logic [WORD_W-1:0]            wdata,
  output logic [WORD_W-1:0]            pend_o,
  output logic [WORD_W-1:0]            enable_o,
  output logic [MBOX_WORDS*WORD_W-1:0] mbox_o,
  output logic                         irq_o
);

  logic [WORD_W-1:0] pend_q;
  logic [WORD_W-1:0] enable_q;
  logic [WORD_W-1:0] mbox_q [MBOX_WORDS];
  logic              irq_q;

  logic [WORD_W-1:0] pend_set_val;
  logic [WORD_W-1:0] pend_clr_val;
  logic              raise_evt;
  logic              lower_evt;

  assign pend_set_val = pend_after_set(pend_q, set_bits);
  assign pend_clr_val = pend_after_clear(pend_q, wdata);
  assign raise_evt    = set_we && ((pend_set_val & enable_q) != '0);
  assign lower_evt    = clr_we && (pend_clr_val == '0) && (enable_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      enable_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (en_we) enable_q <= wdata;
      if (set_we) begin
        pend_q <= pend_set_val;
        irq_q  <= irq_after_set(irq_q, pend_set_val, enable_q);
      end else if (clr_we) begin
        pend_q <= pend_clr_val;
        irq_q  <= irq_after_clear(irq_q, pend_clr_val, enable_q);
      end
    end
  end

  for (genvar w = 0; w < MBOX_WORDS; w++) begin : g_mbox
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    mbox_q[w] <= '0;
      else if (mbox_we && mbox_idx == MBOX_IDX_W'(w)) mbox_q[w] <= wdata;
    end
    assign mbox_o[w*WORD_W +: WORD_W] = mbox_q[w];
  end

  assign pend_o   = pend_q;
  assign enable_o = enable_q;
  assign irq_o    = irq_q;

  AST_SET_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    raise_evt |=> irq_o); // R3
  AST_CLEAR_LOWERS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    lower_evt |=> !irq_o); // R4
  AST_CLEAR_ADDS_NO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((pend_o & ~$past(pend_o)) == '0)); // R4
  AST_IRQ_ONLY_VIA_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(irq_o)); // R5
  AST_PEND_ONLY_VIA_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(pend_o)); // R2

endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_ctrl_pkg::*;
#(
  parameter int unsigned NCORES = 4,
  parameter int unsigned ID_W   = 10,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_id,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic [NCORES-1:0] irq_o
);

  localparam int unsigned BANK_W = NCORES * WORD_W;

  acc_kind_e             kind;
  logic [MBOX_IDX_W-1:0] mbox_idx;
  logic [NCORES-1:0]     local_hit;
  logic [NCORES-1:0]     send_hit;
  logic [WORD_W-1:0]     send_mask;
  logic                  acc_err;
  logic [WORD_W-1:0]     core_rd [NCORES];
  logic [WORD_W-1:0]     rd_next;
  logic [BANK_W-1:0]     pend_flat;
  logic [BANK_W-1:0]     enable_flat;
  logic                  unused_addr_hi;

  assign unused_addr_hi = ^req_addr[ADDR_W-1:8];

  ipi_access_decode #(.NCORES(NCORES), .ID_W(ID_W)) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_off   (req_addr[7:0]),
    .req_id    (req_id),
    .send_tgt  (req_wdata[TGT_LSB +: TGT_W]),
    .send_vec  (req_wdata[VEC_W-1:0]),
    .kind      (kind),
    .mbox_idx  (mbox_idx),
    .local_hit (local_hit),
    .send_hit  (send_hit),
    .send_mask (send_mask),
    .acc_err   (acc_err)
  );

  for (genvar i = 0; i < NCORES; i++) begin : g_core
    logic                         wr_here;
    logic                         set_we;
    logic [WORD_W-1:0]            set_bits;
    logic [WORD_W-1:0]            pend;
    logic [WORD_W-1:0]            enable;
    logic [MBOX_WORDS*WORD_W-1:0] mbox;

    assign wr_here  = local_hit[i] && req_write;
    assign set_we   = (wr_here && kind == ACC_SET) || send_hit[i];
    assign set_bits = send_hit[i] ? send_mask : req_wdata;

    ipi_core_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_we    (wr_here && kind == ACC_ENABLE),
      .set_we   (set_we),
      .set_bits (set_bits),
      .clr_we   (wr_here && kind == ACC_CLEAR),
      .mbox_we  (wr_here && kind == ACC_MBOX),
      .mbox_idx (mbox_idx),
      .wdata    (req_wdata),
      .pend_o   (pend),
      .enable_o (enable),
      .mbox_o   (mbox),
      .irq_o    (irq_o[i])
    );

    always_comb begin
      case (kind)
        ACC_PEND:   core_rd[i] = pend;
        ACC_ENABLE: core_rd[i] = enable;
        ACC_MBOX:   core_rd[i] = mbox[mbox_idx*WORD_W +: WORD_W];
        default:    core_rd[i] = '0;
      endcase
    end

    assign pend_flat[i*WORD_W +: WORD_W]   = pend;
    assign enable_flat[i*WORD_W +: WORD_W] = enable;
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NCORES; i++) begin
      if (local_hit[i] && !req_write) rd_next = rd_next | core_rd[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= req_valid ? rd_next : '0;
      rsp_err   <= req_valid && acc_err;
    end
  end

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R10
  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_err)); // R10
  AST_SEND_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(send_hit)); // R7
  AST_REFUSED_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> ($stable(pend_flat) && $stable(enable_flat) && $stable(irq_o))); // R8
  AST_ERR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> rsp_err); // R2

endmodule

// File: tb/ipi_ctrl_test.sv
module ipi_ctrl_test;

  localparam int NC  = 3;
  localparam int IDW = 10;
  localparam int AW  = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [IDW-1:0] req_id = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          rsp_err;
  logic [NC-1:0] irq_o;

  int errors = 0;
  int checks = 0;

  logic [31:0] m_pend [NC];
  logic [31:0] m_en   [NC];
  logic [31:0] m_mbox [NC][8];
  logic        m_irq  [NC];

  always #10 clk = ~clk;

  ipi_ctrl #(.NCORES(NC), .ID_W(IDW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_id(req_id), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] model_irq();
    logic [NC-1:0] v;
    for (int i = 0; i < NC; i++) v[i] = m_irq[i];
    return v;
  endfunction

  function automatic void model_set(input int c, input logic [31:0] bits);
    m_pend[c] = m_pend[c] | bits;
    if ((m_pend[c] & m_en[c]) != 0) m_irq[c] = 1'b1;
  endfunction

  function automatic void model_clear(input int c, input logic [31:0] bits);
    m_pend[c] = m_pend[c] & ~bits;
    if (m_pend[c] == 0 && m_en[c] != 0) m_irq[c] = 1'b0;
  endfunction

  function automatic void model_access(input bit wr, input logic [AW-1:0] addr,
                                       input logic [IDW-1:0] id, input logic [31:0] wd,
                                       output logic [31:0] rd, output bit err);
    logic [7:0] off;
    bit vc;
    bit is_mb;
    int tgt;
    off   = addr[7:0];
    vc    = (int'(id) < NC);
    is_mb = (off >= 8'h20 && off <= 8'h3C && off[1:0] == 2'b00);
    rd    = '0;
    err   = 1'b0;
    if (wr) begin
      if (off == 8'h00) err = 1'b1;
      else if (off == 8'h04 && vc) m_en[id] = wd;
      else if (off == 8'h08 && vc) model_set(int'(id), wd);
      else if (off == 8'h0C && vc) model_clear(int'(id), wd);
      else if (is_mb && vc) m_mbox[id][(off - 8'h20) >> 2] = wd;
      else if (off == 8'h40) begin
        tgt = int'(wd[25:16]);
        if (tgt < NC) model_set(tgt, 32'h1 << wd[4:0]);
        else err = 1'b1;
      end
    end else if (vc) begin
      if (off == 8'h00) rd = m_pend[id];
      else if (off == 8'h04) rd = m_en[id];
      else if (is_mb) rd = m_mbox[id][(off - 8'h20) >> 2];
    end
  endfunction

  task automatic access(input bit wr, input logic [AW-1:0] addr, input logic [IDW-1:0] id,
                        input logic [31:0] wd, input string tag);
    logic [31:0] exp_rd;
    bit exp_err;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_id = id; req_wdata = wd;
    model_access(wr, addr, id, wd, exp_rd, exp_err);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, {tag, " R10 rsp_valid"}, 32'(rsp_valid), 32'h1);
    chk(rsp_rdata === exp_rd, {tag, " rdata"}, rsp_rdata, exp_rd);
    chk(rsp_err === exp_err, {tag, " err"}, 32'(rsp_err), 32'(exp_err));
    chk(irq_o === model_irq(), {tag, " irq"}, 32'(irq_o), 32'(model_irq()));
  endtask

  function automatic logic [AW-1:0] pick_addr();
    logic [7:0] off;
    int r;
    r = $urandom_range(0, 9);
    case (r)
      0: off = 8'h00;
      1: off = 8'h04;
      2, 3: off = 8'h08;
      4: off = 8'h0C;
      5, 6: off = 8'h20 + 8'($urandom_range(0, 7) * 4);
      7: off = 8'h40;
      8: off = 8'($urandom_range(0, 255));
      default: off = 8'h10 + 8'($urandom_range(0, 3));
    endcase
    return {4'($urandom_range(0, 15)), off};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NC; i++) begin
      m_pend[i] = '0; m_en[i] = '0; m_irq[i] = 1'b0;
      for (int w = 0; w < 8; w++) m_mbox[i][w] = '0;
    end
    repeat (3) @(negedge clk);
    chk(irq_o === '0, "R1 irq after reset", 32'(irq_o), 32'h0);
    chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'h0);
    rst_n = 1'b1;

    // R1: every bank reads zero
    for (int c = 0; c < NC; c++) begin
      access(0, 12'h000, IDW'(c), 0, "R1 pend");
      access(0, 12'h004, IDW'(c), 0, "R1 enable");
      for (int w = 0; w < 8; w++) access(0, AW'(8'h20 + w*4), IDW'(c), 0, "R1 mbox");
    end

    // R2: pending word not writable
    access(1, 12'h000, 0, 32'hFFFF_FFFF, "R2 write pend");
    access(0, 12'h000, 0, 0, "R2 pend unchanged");

    // R3/R4/R5 asymmetric interrupt rules on core 0
    access(1, 12'h004, 0, 32'h0000_0001, "R5 enable write");
    access(1, 12'h008, 0, 32'h0000_0002, "R3 set not enabled");
    access(1, 12'h008, 0, 32'h0000_0001, "R3 set raises");
    access(1, 12'h00C, 0, 32'h0000_0001, "R4 partial clear keeps irq");
    access(1, 12'h004, 0, 32'h0000_0000, "R5 enable zero keeps irq");
    access(1, 12'h00C, 0, 32'hFFFF_FFFF, "R4 empty with enable zero keeps irq");
    access(1, 12'h004, 0, 32'h0000_0010, "R5 enable keeps irq");
    access(1, 12'h00C, 0, 32'h0000_0000, "R4 empty with enable lowers");
    access(0, 12'h008, 0, 0, "R5 set reads zero");
    access(0, 12'h00C, 0, 0, "R5 clear reads zero");

    // R6 mailbox round trip
    access(1, 12'h03C, 2, 32'hCAFE_0007, "R6 mbox7 write");
    access(1, 12'h020, 2, 32'h1234_5670, "R6 mbox0 write");
    access(0, 12'h03C, 2, 0, "R6 mbox7 read");
    access(0, 12'h020, 2, 0, "R6 mbox0 read");
    access(0, 12'h03C, 1, 0, "R6 other bank untouched");

    // R7 / R8 send
    access(1, 12'h004, 1, 32'h8000_0000, "R7 enable core1");
    access(1, 12'h040, 0, {6'd0, 10'd1, 11'd0, 5'd31}, "R7 send vec31 to core1");
    access(0, 12'h000, 1, 0, "R7 pend core1");
    access(1, 12'h040, 7, {6'd0, 10'd3, 11'd0, 5'd4}, "R8 send target 3");
    access(1, 12'h040, 0, {6'd0, 10'd1023, 11'd0, 5'd0}, "R8 send target 1023");
    access(0, 12'h000, 1, 0, "R8 pend unchanged");

    // R9 undecoded, high address bits, bad requester
    access(1, 12'hF04, 0, 32'h0000_00FF, "R9 high addr bits ignored");
    access(0, 12'h504, 0, 0, "R9 high addr read");
    access(1, 12'h022, 0, 32'hDEAD_BEEF, "R9 unaligned mbox write");
    access(0, 12'h020, 0, 0, "R9 mbox0 after unaligned");
    access(0, 12'h044, 0, 0, "R9 undecoded read");
    access(1, 12'h008, 5, 32'hFFFF_FFFF, "R9 bad requester set");
    access(0, 12'h004, 5, 0, "R9 bad requester read");

    // constrained random mix
    for (int n = 0; n < 800; n++) begin
      logic [IDW-1:0] id;
      logic [31:0] wd;
      bit wr;
      id = ($urandom_range(0, 9) == 0) ? IDW'($urandom_range(3, 1023)) : IDW'($urandom_range(0, NC-1));
      wr = ($urandom_range(0, 2) != 0);
      case ($urandom_range(0, 3))
        0: wd = 32'hFFFF_FFFF;
        1: wd = 32'($urandom_range(0, 15));
        2: wd = {6'd0, (($urandom_range(0, 5) == 0) ? 10'($urandom_range(3, 1023))
                                                     : 10'($urandom_range(0, NC-1))),
                 11'd0, 5'($urandom_range(0, 31))};
        default: wd = $urandom;
      endcase
      access(wr, pick_addr(), id, wd, "R3 R4 R7 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule